// File: doc/BRIEF.md
# Complementary PWM Pair with Dead-Time Insertion

This block generates one pulse-width modulated reference and turns it into two non-overlapping drive signals, a main output and its complement, for the high and low switches of one half-bridge leg. A programmable clock divider sets the tick rate. An up-counter runs from zero to a period limit and wraps. A compare threshold sets how long the reference stays active in each period. Before either output turns on after a reference transition, a guard interval passes, and its length comes from a compact 8-bit code.

Software programs the block through a write-only register port. Period and threshold writes land in preload registers. These move into the working copies when the counter wraps or when software requests an update, so a change in the middle of a period never cuts a pulse short. Each output has its own enable and polarity. A master output gate forces both pins to programmed idle levels. The dead-time code is read live, so a new value applies to the next transition.

Register map (word addresses on `wr_addr`): 0 control, 1 divider, 2 period, 3 threshold, 4 dead-time code, 5 update request (the written data is ignored).

Top module: `pwm_pair_dt`

## Requirements
- R1: After reset both pins are low, the counter is stopped, and all registers hold zero.
- R2: While running, the counter advances once every DIV+1 clocks, where DIV is the divider value. It counts from 0 up to PERIOD and then returns to 0, so one period lasts (PERIOD+1)*(DIV+1) clocks.
- R3: With the control mode field (control bits 10:8) set to 3'b110, the reference is active while the counter is below THRESHOLD. Any other mode code keeps the reference inactive.
- R4: Writes to the period and threshold registers take effect only at a counter wrap or an update request.
- R5: A write to address 5 loads the divider, period and threshold immediately and restarts both the divider and the counter at 0.
- R6: The main output rises a dead-time after the reference rises and falls with it. The complementary output rises a dead-time after the reference falls and falls when the reference rises. If the dead-time is longer than a pulse, that output stays inactive for the whole pulse. The two active levels never overlap.
- R7: Dead-time in clocks from code C: if C[7]=0 it is C[6:0]; if C[7:6]=10 it is (64+C[5:0])*2; if C[7:5]=110 it is (32+C[4:0])*8; if C[7:5]=111 it is (32+C[4:0])*16.
- R8: Rewriting the dead-time code while running changes the guard interval of later transitions without stopping the counter.
- R9: Control bit 2 enables the main output and bit 4 the complementary output. Bit 3 and bit 5 invert their active levels, applied after dead-time. While the gate is set, a disabled output drives its polarity bit.
- R10: While the gate (control bit 1) is clear, the main pin drives control bit 6 and the complementary pin drives control bit 7, whatever the counter state.
- R11: With the run bit (control bit 0) clear, the counter and the reference hold their values, so the pins hold too.
- R12: The pins are registered. They change one clock after the state that sets them.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 16 | Register write data |
| out_pos | output | 1 | Main drive output |
| out_neg | output | 1 | Complementary drive output |

## Verification
The bench uses the default 16-bit counter width. It pairs short periods of 20 and 40 ticks, where every transition and every preload hand-over happens many times, with a 1200-clock period that is long enough for all four dead-time code ranges, including intervals of several hundred clocks and a guard that swallows a whole pulse. A divider of 2 exercises tick pacing. Control words cover polarity inversion, a disabled output, the gate-off idle levels, a non-PWM mode, and a stopped counter.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

  localparam int ADDR_W = 3;
  localparam int DT_W   = 10;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_DIV    = 3'd1,
    A_PERIOD = 3'd2,
    A_THRESH = 3'd3,
    A_DEAD   = 3'd4,
    A_UPDATE = 3'd5
  } reg_addr_e;

  localparam logic [2:0] MODE_PWM1 = 3'b110;

  // control word, bit 0 is run, bits 10:8 are mode
  typedef struct packed {
    logic [2:0] mode;
    logic       idle_neg;
    logic       idle_pos;
    logic       neg_pol;
    logic       neg_en;
    logic       pos_pol;
    logic       pos_en;
    logic       gate;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // expand the compact guard code into a clock count
  function automatic logic [DT_W-1:0] dead_ticks(input logic [7:0] code);
    logic [DT_W-1:0] t;
    if (!code[7])      t = {3'b000, code[6:0]};
    else if (!code[6]) t = {2'b00, 1'b1, code[5:0], 1'b0};
    else if (!code[5]) t = {1'b0, 1'b1, code[4:0], 3'b000};
    else               t = {1'b1, code[4:0], 4'b0000};
    return t;
  endfunction

endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  output ctrl_t              ctrl,
  output logic [CNT_W-1:0]   div_pre,
  output logic [CNT_W-1:0]   period_pre,
  output logic [CNT_W-1:0]   thresh_pre,
  output logic [7:0]         dead_code,
  output logic               upd
);

  ctrl_t            ctrl_q, ctrl_n;
  logic [CNT_W-1:0] div_q, div_n, per_q, per_n, thr_q, thr_n;
  logic [7:0]       dead_q, dead_n;

  always_comb begin
    ctrl_n = ctrl_q;
    div_n  = div_q;
    per_n  = per_q;
    thr_n  = thr_q;
    dead_n = dead_q;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL:   ctrl_n = ctrl_t'(wr_data[CTRL_W-1:0]);
        A_DIV:    div_n  = wr_data;
        A_PERIOD: per_n  = wr_data;
        A_THRESH: thr_n  = wr_data;
        A_DEAD:   dead_n = wr_data[7:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      per_q  <= '0;
      thr_q  <= '0;
      dead_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      div_q  <= div_n;
      per_q  <= per_n;
      thr_q  <= thr_n;
      dead_q <= dead_n;
    end
  end

  assign ctrl       = ctrl_q;
  assign div_pre    = div_q;
  assign period_pre = per_q;
  assign thresh_pre = thr_q;
  assign dead_code  = dead_q;
  assign upd        = wr_en && (wr_addr == A_UPDATE);

endmodule

// File: rtl/pwm_pair_timebase.sv
module pwm_pair_timebase
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              upd,
  input  logic [2:0]        mode,
  input  logic [CNT_W-1:0]  div_pre,
  input  logic [CNT_W-1:0]  period_pre,
  input  logic [CNT_W-1:0]  thresh_pre,
  output logic [CNT_W-1:0]  cnt,
  output logic              ref_lvl
);

  logic [CNT_W-1:0] div_act_q, div_act_n;
  logic [CNT_W-1:0] per_act_q, per_act_n;
  logic [CNT_W-1:0] thr_act_q, thr_act_n;
  logic [CNT_W-1:0] pre_q, pre_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ref_q, ref_n;
  logic             tick, wrap;

  always_comb begin
    div_act_n = div_act_q;
    per_act_n = per_act_q;
    thr_act_n = thr_act_q;
    pre_n     = pre_q;
    cnt_n     = cnt_q;
    ref_n     = ref_q;
    tick      = run && (pre_q >= div_act_q);
    wrap      = tick && (cnt_q >= per_act_q);

    if (run) ref_n = (mode == MODE_PWM1) && (cnt_q < thr_act_q);

    if (upd) begin
      pre_n     = '0;
      cnt_n     = '0;
      div_act_n = div_pre;
      per_act_n = period_pre;
      thr_act_n = thresh_pre;
    end else if (run) begin
      if (tick) begin
        pre_n = '0;
        if (wrap) begin
          cnt_n     = '0;
          div_act_n = div_pre;
          per_act_n = period_pre;
          thr_act_n = thresh_pre;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        pre_n = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act_q <= '0;
      per_act_q <= '0;
      thr_act_q <= '0;
      pre_q     <= '0;
      cnt_q     <= '0;
      ref_q     <= 1'b0;
    end else begin
      div_act_q <= div_act_n;
      per_act_q <= per_act_n;
      thr_act_q <= thr_act_n;
      pre_q     <= pre_n;
      cnt_q     <= cnt_n;
      ref_q     <= ref_n;
    end
  end

  assign cnt     = cnt_q;
  assign ref_lvl = ref_q;

endmodule

// File: rtl/pwm_pair_deadtime.sv
module pwm_pair_deadtime
  import pwm_pair_pkg::*;
#(
  parameter int AGE_W = DT_W + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_lvl,
  input  logic [7:0] dead_code,
  output logic       pos_raw,
  output logic       neg_raw
);

  logic             seen_q;
  logic [AGE_W-1:0] age_q, age_n, age_now;
  logic [DT_W-1:0]  guard;
  logic             flip;
  logic             matured;

  always_comb begin
    flip    = ref_lvl ^ seen_q;
    age_now = flip ? '0 : age_q;
    guard   = dead_ticks(dead_code);
    matured = age_now >= AGE_W'(guard);
    pos_raw = ref_lvl && matured;
    neg_raw = !ref_lvl && matured;
    if (flip)        age_n = AGE_W'(1);
    else if (&age_q) age_n = age_q;
    else             age_n = age_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      age_q  <= '0;
    end else begin
      seen_q <= ref_lvl;
      age_q  <= age_n;
    end
  end

endmodule

// File: rtl/pwm_pair_outstage.sv
module pwm_pair_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic en,
  input  logic pol,
  input  logic idle,
  input  logic raw,
  output logic pin
);

  logic pin_q, pin_n;

  always_comb begin
    if (!gate)   pin_n = idle;
    else if (en) pin_n = raw ^ pol;
    else         pin_n = pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_n;
  end

  assign pin = pin_q;

endmodule

// File: rtl/pwm_pair_dt.sv
module pwm_pair_dt
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  output logic                out_pos,
  output logic                out_neg
);

  localparam int NCH = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_N-1];

  ctrl_t            ctrl;
  logic [CNT_W-1:0] div_pre, period_pre, thresh_pre, cnt;
  logic [7:0]       dead_code;
  logic             upd, ref_lvl, pos_raw, neg_raw;
  logic             run, gate, pos_en, neg_en, pos_pol, neg_pol, idle_pos, idle_neg;

  assign run      = ctrl.run;
  assign gate     = ctrl.gate;
  assign pos_en   = ctrl.pos_en;
  assign neg_en   = ctrl.neg_en;
  assign pos_pol  = ctrl.pos_pol;
  assign neg_pol  = ctrl.neg_pol;
  assign idle_pos = ctrl.idle_pos;
  assign idle_neg = ctrl.idle_neg;

  pwm_pair_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .div_pre(div_pre), .period_pre(period_pre), .thresh_pre(thresh_pre),
    .dead_code(dead_code), .upd(upd)
  );

  pwm_pair_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk(clk), .rst_n(rst_core_n), .run(run), .upd(upd), .mode(ctrl.mode),
    .div_pre(div_pre), .period_pre(period_pre), .thresh_pre(thresh_pre),
    .cnt(cnt), .ref_lvl(ref_lvl)
  );

  pwm_pair_deadtime u_deadtime (
    .clk(clk), .rst_n(rst_core_n), .ref_lvl(ref_lvl), .dead_code(dead_code),
    .pos_raw(pos_raw), .neg_raw(neg_raw)
  );

  logic [NCH-1:0] ch_en, ch_pol, ch_idle, ch_raw, ch_pin;
  assign ch_en   = {neg_en, pos_en};
  assign ch_pol  = {neg_pol, pos_pol};
  assign ch_idle = {idle_neg, idle_pos};
  assign ch_raw  = {neg_raw, pos_raw};

  for (genvar i = 0; i < NCH; i++) begin : g_out
    pwm_pair_outstage u_stage (
      .clk(clk), .rst_n(rst_core_n), .gate(gate), .en(ch_en[i]), .pol(ch_pol[i]),
      .idle(ch_idle[i]), .raw(ch_raw[i]), .pin(ch_pin[i])
    );
  end

  assign out_pos = ch_pin[0];
  assign out_neg = ch_pin[1];

endmodule

// File: rtl/pwm_pair_dt_chk.sv
module pwm_pair_dt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             run,
  input logic             gate,
  input logic             upd,
  input logic             pos_en,
  input logic             neg_en,
  input logic             pos_pol,
  input logic             neg_pol,
  input logic             idle_pos,
  input logic             idle_neg,
  input logic [CNT_W-1:0] cnt,
  input logic             ref_lvl,
  input logic             pos_raw,
  input logic             neg_raw,
  input logic             out_pos,
  input logic             out_neg
);

  // R10
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !gate |=> (out_pos == $past(idle_pos) && out_neg == $past(idle_neg)));

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (gate && pos_en && neg_en && !pos_pol && !neg_pol) |=> !(out_pos && out_neg));

  // R6
  raw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(pos_raw && neg_raw));

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    upd |=> (cnt == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!run && !upd) |=> ($stable(cnt) && $stable(ref_lvl)));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run && !upd) |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));

endmodule

bind pwm_pair_dt pwm_pair_dt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .run(run), .gate(gate), .upd(upd),
  .pos_en(pos_en), .neg_en(neg_en), .pos_pol(pos_pol), .neg_pol(neg_pol),
  .idle_pos(idle_pos), .idle_neg(idle_neg), .cnt(cnt), .ref_lvl(ref_lvl),
  .pos_raw(pos_raw), .neg_raw(neg_raw), .out_pos(out_pos), .out_neg(out_neg)
);

// File: tb/pwm_pair_dt_bench.sv
module pwm_pair_dt_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        out_pos, out_neg;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_pair_dt u_pwm_pair_dt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_pos(out_pos), .out_neg(out_neg)
  );

  // behavioural reference
  int m_sync, m_ctrl, m_divp, m_perp, m_thrp, m_dead;
  int m_div, m_per, m_thr, m_pre, m_cnt, m_ref, m_age, m_pos, m_neg;

  function automatic int guard_of(int c);
    if (c < 128)      return c;
    else if (c < 192) return (64 + c % 64) * 2;
    else if (c < 224) return (32 + c % 32) * 8;
    else              return (32 + c % 32) * 16;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_ctrl = 0; m_divp = 0; m_perp = 0; m_thrp = 0; m_dead = 0;
      m_div = 0; m_per = 0; m_thr = 0; m_pre = 0; m_cnt = 0; m_ref = 0; m_age = 0;
      m_pos = 0; m_neg = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      int run, g, pe, pp, ne, np, ip, in_, mode, dt, pr, nr, nref;
      run = m_ctrl & 1; g = (m_ctrl >> 1) & 1; pe = (m_ctrl >> 2) & 1; pp = (m_ctrl >> 3) & 1;
      ne = (m_ctrl >> 4) & 1; np = (m_ctrl >> 5) & 1; ip = (m_ctrl >> 6) & 1;
      in_ = (m_ctrl >> 7) & 1; mode = (m_ctrl >> 8) & 7;
      dt = guard_of(m_dead);
      pr = (m_ref == 1 && m_age >= dt) ? 1 : 0;
      nr = (m_ref == 0 && m_age >= dt) ? 1 : 0;
      if (g == 0) begin m_pos = ip; m_neg = in_; end
      else begin
        m_pos = pe ? (pr ^ pp) : pp;
        m_neg = ne ? (nr ^ np) : np;
      end
      nref = run ? ((mode == 6 && m_cnt < m_thr) ? 1 : 0) : m_ref;
      if (nref != m_ref) m_age = 0; else if (m_age < 2047) m_age++;
      m_ref = nref;
      if (wr_en && wr_addr == 3'd5) begin
        m_pre = 0; m_cnt = 0; m_div = m_divp; m_per = m_perp; m_thr = m_thrp;
      end else if (run) begin
        if (m_pre >= m_div) begin
          m_pre = 0;
          if (m_cnt >= m_per) begin m_cnt = 0; m_div = m_divp; m_per = m_perp; m_thr = m_thrp; end
          else m_cnt++;
        end else m_pre++;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_ctrl = int'(wr_data) & 'h7FF;
          3'd1: m_divp = int'(wr_data);
          3'd2: m_perp = int'(wr_data);
          3'd3: m_thrp = int'(wr_data);
          3'd4: m_dead = int'(wr_data) & 255;
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison (R12: registered pins compared cycle-exactly)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (out_pos !== 1'(m_pos) || out_neg !== 1'(m_neg)) begin
        errors++;
        $display("FAIL %s/R12 cycle compare: pos=%b neg=%b expected pos=%0d neg=%0d",
                 cur_req, out_pos, out_neg, m_pos, m_neg);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic count_high(input int n, output int cp, output int cn);
    cp = 0; cn = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cp += int'(out_pos); cn += int'(out_neg);
    end
  endtask

  task automatic expect_counts(input string req, input int n, input int ep, input int en);
    int cp, cn;
    count_high(n, cp, cn);
    checks++;
    if (cp != ep || cn != en) begin
      errors++;
      $display("FAIL %s high counts: pos=%0d neg=%0d expected pos=%0d neg=%0d", req, cp, cn, ep, en);
    end
  endtask

  task automatic setup(input int div, input int per, input int thr, input int dead, input int ctl);
    wr(1, div); wr(2, per); wr(3, thr); wr(4, dead); wr(0, ctl); wr(5, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0, n0, cp, cn;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1: pins low after reset
    checks++;
    if (out_pos !== 1'b0 || out_neg !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset pins: pos=%b neg=%b expected 0 0", out_pos, out_neg);
    end

    // R6 basic dead-time: period 20, threshold 10, guard 3
    cur_req = "R6";
    setup(0, 19, 10, 3, 'h617);
    repeat (60) @(negedge clk);
    expect_counts("R6", 20, 7, 7);

    // R2 divider of 2: 30 clocks high, 30 low
    cur_req = "R2";
    wr(1, 2); wr(5, 0);
    repeat (120) @(negedge clk);
    expect_counts("R2", 60, 27, 27);

    // R4 preload: threshold write applied at wrap only
    cur_req = "R4";
    wr(1, 0); wr(5, 0);
    repeat (45) @(negedge clk);
    wr(3, 15);
    repeat (40) @(negedge clk);
    expect_counts("R4", 20, 12, 2);

    // R5 update: new period takes effect now
    cur_req = "R5";
    wr(2, 39); wr(5, 0);
    repeat (80) @(negedge clk);
    expect_counts("R5", 40, 12, 22);

    // R8 live dead-time change
    cur_req = "R8";
    wr(2, 19); wr(3, 10); wr(5, 0);
    repeat (40) @(negedge clk);
    wr(4, 5);
    repeat (40) @(negedge clk);
    expect_counts("R8", 20, 5, 5);

    // R7 code ranges at a 1200-clock period, threshold 600
    cur_req = "R7";
    setup(0, 1199, 600, 'h7F, 'h617);
    repeat (1300) @(negedge clk);
    expect_counts("R7 code 0x7F", 1200, 473, 473);
    wr(4, 'h85);
    repeat (1300) @(negedge clk);
    expect_counts("R7 code 0x85", 1200, 462, 462);
    wr(4, 'hC1);
    repeat (1300) @(negedge clk);
    expect_counts("R7 code 0xC1", 1200, 336, 336);
    wr(4, 'hE1);
    repeat (1300) @(negedge clk);
    expect_counts("R7 code 0xE1", 1200, 72, 72);

    // R6 guard longer than pulse: threshold 20, guard 528
    cur_req = "R6";
    wr(3, 20); wr(5, 0);
    repeat (1300) @(negedge clk);
    expect_counts("R6 swallowed pulse", 1200, 0, 652);

    // R9 inverted main output, complement disabled
    cur_req = "R9";
    wr(3, 600); wr(4, 'h7F); wr(0, 'h60F); wr(5, 0);
    repeat (1300) @(negedge clk);
    expect_counts("R9", 1200, 727, 0);

    // R10 gate off: idle levels
    cur_req = "R10";
    wr(0, 'h655);
    repeat (10) @(negedge clk);
    expect_counts("R10", 1200, 1200, 0);

    // R3 non-PWM mode keeps reference inactive
    cur_req = "R3";
    wr(0, 'h017);
    repeat (1300) @(negedge clk);
    expect_counts("R3", 1200, 0, 1200);

    // R11 stopped counter holds pins
    cur_req = "R11";
    setup(0, 19, 10, 0, 'h617);
    repeat (25) @(negedge clk);
    wr(0, 'h616);
    repeat (5) @(negedge clk);
    p0 = int'(out_pos); n0 = int'(out_neg);
    count_high(50, cp, cn);
    checks++;
    if (cp != 50 * p0 || cn != 50 * n0) begin
      errors++;
      $display("FAIL R11 hold: pos=%0d neg=%0d expected pos=%0d neg=%0d", cp, cn, 50 * p0, 50 * n0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule